// File: doc/BRIEF.md
# Link Error Attention Aggregator

This block turns the error traffic of a link layer into a single attention line for firmware. Four 16-bit event counters track TLP errors, TLP bad-sequence events, DLLP errors and received NAKs. Each counter has a programmable threshold and a sticky indicator. A fifth indicator is raised while any of five latched link status flags is held. The status flags cover flow-control update timeout, flow-control receive overflow, flow-control protocol error, data link protocol error, and replay rollover or timeout. A read/write mask selects which of the five indicators may drive the attention output.

Software uses a simple word-addressed register port. An indicator is never cleared by writing to it. A counter indicator clears when software reads the counter it watches, and that read also zeroes the counter. The status indicator clears when the status word is read, because the read clears the latched flags behind it. The attention output is registered.

Top module: `link_attn_agg`

## Requirements
- R1: After reset the indicator word (address 0) reads 0. Its bit i (i = 0..3) belongs to counter i: 0 TLP error, 1 TLP bad sequence, 2 DLLP error, 3 NAK received. Bit 4 is the status aggregate, and bits 31:5 read 0.
- R2: Counter i (read at address 3+i) increments once per cycle in which `cnt_evt[i]` is high. It saturates at 65535 and reads in bits 15:0 with the upper bits 0.
- R3: Counter indicator i sets in the cycle after counter i holds a value greater than or equal to threshold i. It then stays set until counter i is read.
- R4: A counter read returns the current count, zeroes the counter and clears its indicator. An event in the same cycle as the read leaves the counter at 1.
- R5: Threshold i is read/write at address 7+i in bits 15:0 and resets to 65535. With a threshold of 0, the indicator sets again one cycle after it is cleared by a read.
- R6: Status word (address 2) bit j latches `sts_evt[j]` (j = 0..4). Indicator bit 4 is high while any status bit is set. Reading the status word returns and clears the flags, except that an event arriving in the read cycle stays latched.
- R7: The mask word (address 1) holds bits 7:0 as written and reads bits 31:8 as 0. Mask bits 7:5 have no effect on the attention output.
- R8: `attn` is high exactly one cycle after a cycle in which (indicator AND mask bits 4:0) is non-zero.
- R9: The indicator word is read-only. Writing it changes nothing, and reading it clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe, read side effects at the clock edge |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the current state |
| cnt_evt | input | 4 | Per-cycle event inputs for the four counters |
| sts_evt | input | 5 | Single-cycle status error pulses |
| attn | output | 1 | Registered masked attention |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high together, and that a read strobe lasts exactly one cycle per intended access, since every read-strobe cycle clears its target. They also assume that the status inputs are pulses, so a level held across a status read simply re-latches. The stimulus drives every access as a single-cycle strobe and changes inputs only on the falling edge. It holds a counter event high across many cycles only where saturation is under test.

// File: rtl/link_attn_pkg.sv
package link_attn_pkg;
    localparam int CNT_N  = 4;
    localparam int STS_N  = 5;
    localparam int IND_W  = CNT_N + 1;
    localparam int A_IND  = 0;
    localparam int A_MASK = 1;
    localparam int A_STS  = 2;
    localparam int A_CNT0 = 3;
    localparam int A_THR0 = A_CNT0 + CNT_N;
endpackage

// File: rtl/link_attn_ctr.sv
module link_attn_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         evt,
    input  logic         rd_clr,
    input  logic         thr_wr,
    input  logic [W-1:0] thr_wdata,
    output logic [W-1:0] cnt,
    output logic [W-1:0] thr,
    output logic         flag
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] thr;
        logic         flag;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_clr) begin
            st_d.cnt = {{(W-1){1'b0}}, evt};
        end else if (evt && (st_q.cnt != {W{1'b1}})) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.flag = rd_clr ? 1'b0 : (st_q.flag | (st_q.cnt >= st_q.thr));
        if (thr_wr) begin
            st_d.thr = thr_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.thr  <= '1;
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt  = st_q.cnt;
    assign thr  = st_q.thr;
    assign flag = st_q.flag;

    // R2: a saturated counter stays at its maximum until read
    a_r2_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == {W{1'b1}} && !rd_clr) |=> (cnt == {W{1'b1}}));
    // R3: indicator is sticky while no read occurs
    a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !rd_clr) |=> flag);
    // R4: a counter read leaves the indicator clear
    a_r4_rd_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> !flag);
endmodule

// File: rtl/link_attn_sts.sv
module link_attn_sts #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         rd_clr,
    output logic [N-1:0] flags
);
    typedef struct packed {
        logic [N-1:0] flags;
    } sts_t;

    sts_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.flags = (rd_clr ? '0 : st_q.flags) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flags <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.flags;

    // R6: every pulse is latched, even in a read cycle
    a_r6_evt_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((flags & $past(evt)) == $past(evt)));
endmodule

// File: rtl/link_attn_agg.sv
module link_attn_agg
    import link_attn_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int MASK_W = 8,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_N-1:0]  cnt_evt,
    input  logic [STS_N-1:0]  sts_evt,
    output logic              attn
);
    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic              attn;
    } top_t;

    top_t st_d, st_q;

    logic [CNT_W-1:0] cnt_v [CNT_N];
    logic [CNT_W-1:0] thr_v [CNT_N];
    logic [CNT_N-1:0] flag_v;
    logic [STS_N-1:0] sts_v;
    logic [IND_W-1:0] ind;
    logic             sts_rd;

    assign sts_rd = bus_rd && (bus_addr == ADDR_W'(A_STS));

    for (genvar i = 0; i < CNT_N; i++) begin : g_ctr
        logic rd_hit, wr_hit;
        assign rd_hit = bus_rd && (bus_addr == ADDR_W'(A_CNT0 + i));
        assign wr_hit = bus_wr && (bus_addr == ADDR_W'(A_THR0 + i));
        link_attn_ctr #(.W(CNT_W)) u_ctr (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt       (cnt_evt[i]),
            .rd_clr    (rd_hit),
            .thr_wr    (wr_hit),
            .thr_wdata (bus_wdata),
            .cnt       (cnt_v[i]),
            .thr       (thr_v[i]),
            .flag      (flag_v[i])
        );
    end

    link_attn_sts #(.N(STS_N)) u_sts (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (sts_evt),
        .rd_clr (sts_rd),
        .flags  (sts_v)
    );

    assign ind = {|sts_v, flag_v};

    always_comb begin
        st_d = st_q;
        if (bus_wr && (bus_addr == ADDR_W'(A_MASK))) begin
            st_d.mask = bus_wdata[MASK_W-1:0];
        end
        st_d.attn = |(ind & st_q.mask[IND_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_IND))  bus_rdata = DATA_W'(ind);
        if (bus_addr == ADDR_W'(A_MASK)) bus_rdata = DATA_W'(st_q.mask);
        if (bus_addr == ADDR_W'(A_STS))  bus_rdata = DATA_W'(sts_v);
        for (int i = 0; i < CNT_N; i++) begin
            if (bus_addr == ADDR_W'(A_CNT0 + i)) bus_rdata = DATA_W'(cnt_v[i]);
            if (bus_addr == ADDR_W'(A_THR0 + i)) bus_rdata = DATA_W'(thr_v[i]);
        end
    end

    assign attn = st_q.attn;

    // R7: a mask write lands as written in the next cycle
    a_r7_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(A_MASK)) |=> (st_q.mask == $past(bus_wdata[MASK_W-1:0])));
    // R8: with the live mask bits all clear, attention is low next cycle
    a_r8_attn_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mask[IND_W-1:0] == '0) |=> !attn);
    // R6: status aggregate bit follows the latched flags
    a_r6_ind_agg: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_v == '0) |-> !ind[IND_W-1]);
endmodule

// File: tb/sim_link_attn_agg.sv
module sim_link_attn_agg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  cnt_evt = '0;
    logic [4:0]  sts_evt = '0;
    logic        attn;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    link_attn_agg u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_evt(cnt_evt), .sts_evt(sts_evt), .attn(attn)
    );

    // counter index, threshold, event count, expected indicator bit
    localparam int VEC [6][4] = '{
        '{0, 3, 2, 0}, '{0, 3, 3, 1}, '{1, 1, 1, 1},
        '{2, 5, 7, 1}, '{3, 4, 3, 0}, '{3, 2, 2, 1}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic fire(int idx, int n);
        cnt_evt = 4'(1 << idx);
        repeat (n) @(posedge clk);
        @(negedge clk);
        cnt_evt = '0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R5 reset state
        rd(0, rv); check("R1 reset indicator", rv, 0);
        rd(1, rv); check("R7 reset mask", rv, 0);
        rd(7, rv); check("R5 reset threshold", rv, 32'h0000_FFFF);
        rd(2, rv); check("R6 reset status", rv, 0);
        check("R8 reset attn", 32'(attn), 0);

        // R2 R3 R4 table walk
        foreach (VEC[k]) begin
            wr(4'(7 + VEC[k][0]), 16'(VEC[k][1]));
            fire(VEC[k][0], VEC[k][2]);
            idle(2);
            rd(0, rv);
            check("R3 indicator vs threshold", 32'(rv[VEC[k][0]]), 32'(VEC[k][3]));
            check("R1 upper indicator bits", 32'(rv[31:5]), 0);
            rd(4'(3 + VEC[k][0]), rv);
            check("R2 counter value", rv, 32'(VEC[k][2]));
            rd(0, rv);
            check("R4 indicator cleared by counter read", 32'(rv[VEC[k][0]]), 0);
            wr(4'(7 + VEC[k][0]), 16'hFFFF);
        end

        // R9 indicator read-only, read without side effect
        wr(7, 16'd1); fire(0, 1); idle(2);
        wr(0, 16'hFFFF);
        rd(0, rv); check("R9 write to indicator ignored", 32'(rv[0]), 1);
        rd(0, rv); check("R9 indicator read does not clear", 32'(rv[0]), 1);
        rd(3, rv); wr(7, 16'hFFFF); rd(3, rv);

        // R7 mask width and spare bits
        wr(1, 16'hFFFF); rd(1, rv); check("R7 mask readback", rv, 32'h0000_00FF);
        wr(1, 16'h00E0);
        wr(8, 16'd1); fire(1, 1); idle(3);
        check("R7 spare mask bits inert", 32'(attn), 0);
        wr(1, 16'h0002); idle(1);
        check("R8 attn asserted", 32'(attn), 1);
        rd(4, rv);
        check("R8 attn one cycle after clear", 32'(attn), 1);
        idle(1);
        check("R8 attn dropped", 32'(attn), 0);
        wr(8, 16'hFFFF); rd(4, rv);

        // R4 read coinciding with event
        fire(2, 3);
        cnt_evt = 4'b0100;
        rd(5, rv); cnt_evt = '0;
        check("R4 read returns count", rv, 3);
        rd(5, rv); check("R4 coincident event counted", rv, 1);

        // R5 threshold zero re-sets
        wr(10, 16'd0); idle(1);
        rd(6, rv); check("R5 counter zero", rv, 0);
        rd(0, rv); check("R5 cleared right after read", 32'(rv[3]), 0);
        rd(0, rv); check("R5 re-set one cycle later", 32'(rv[3]), 1);
        wr(10, 16'hFFFF); rd(6, rv); idle(1);
        rd(0, rv); check("R5 indicator clear after restore", 32'(rv[3]), 0);

        // R6 status latch, aggregate, read-clear, coincident keep
        wr(1, 16'h0010);
        sts_evt = 5'b00100; @(posedge clk); @(negedge clk); sts_evt = '0;
        rd(0, rv); check("R6 aggregate bit set", 32'(rv[4]), 1);
        check("R8 attn from status", 32'(attn), 1);
        sts_evt = 5'b00001;
        rd(2, rv); sts_evt = '0;
        check("R6 status read value", rv, 4);
        rd(2, rv); check("R6 coincident event kept", rv, 1);
        rd(2, rv); check("R6 status cleared", rv, 0);
        rd(0, rv); check("R6 aggregate bit clear", 32'(rv[4]), 0);
        idle(1);
        check("R8 attn low after status clear", 32'(attn), 0);
        wr(1, 16'h0000);

        // R2 saturation
        fire(0, 65540);
        idle(2);
        rd(0, rv); check("R3 indicator at max threshold", 32'(rv[0]), 1);
        rd(3, rv); check("R2 counter saturates", rv, 32'h0000_FFFF);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung run, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule